// File: doc/BRIEF.md
# Audio Sample Format Unpacker

This block sits between a memory read stream and a parallel-to-serial audio converter. It takes 32-bit words that hold audio samples in increasing address order. It cuts each word into left/right pairs of 16-bit samples. Four storage formats are handled: mono or stereo, each with 8-bit or 16-bit samples. A byte-order input decides which byte lane of a word holds the lowest address. Narrow samples are widened to 16 bits before they leave the block.

Words arrive on a valid/ready port, and pairs leave on a second valid/ready port. A word is held until its last pair has been taken. The format, byte-order and sign options are captured together with each word, so a change on those pins only applies from the next accepted word.

Top module: `aud_unpacker`

## Requirements
- R1: The format code `fmt_i` selects the number of pairs a word yields: 0 = 8-bit mono gives 4 pairs, 1 = 8-bit stereo gives 2, 2 = 16-bit mono gives 2, and 3 = 16-bit stereo gives 1. `pair_valid_o` is high exactly while pairs of an accepted word remain.
- R2: Samples leave in increasing address order. In stereo formats the lower address of each pair goes to `left_o` and the next address goes to `right_o`.
- R3: With `lsb_first_i` = 1, address offset k in a word is byte `word_i[8k+7:8k]`, and a 16-bit sample at offset 2h is `word_i[16h+15:16h]`.
- R4: With `lsb_first_i` = 0, address offset k is byte `word_i[31-8k:24-8k]`, and a 16-bit sample at offset 2h is `word_i[31-16h:16-16h]`.
- R5: An 8-bit sample is placed in bits [15:8] of the output, and bits [7:0] are zero.
- R6: In 8-bit formats with `flip_msb_i` = 1, bit 15 of each output sample is the inverse of the stored sample's MSB.
- R7: In 16-bit formats `flip_msb_i` has no effect, and the stored 16-bit value is output unchanged.
- R8: In mono formats `left_o` and `right_o` carry the same sample.
- R9: While `pair_valid_o` is high and `pair_ready_i` is low, `pair_valid_o`, `left_o` and `right_o` stay unchanged on the next cycle.
- R10: `word_ready_o` is high only when no pair is held, or when the last pair of the held word is taken in the same cycle.
- R11: During reset `pair_valid_o` is low and `word_ready_o` is high.
- R12: Format, byte order and sign option are taken from the pins in the cycle a word is accepted. Later changes on those pins do not alter the pairs of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Format code (see R1) |
| lsb_first_i | input | 1 | 1: lowest address in least significant byte lane |
| flip_msb_i | input | 1 | Invert MSB of 8-bit samples |
| word_valid_i | input | 1 | Input word valid |
| word_ready_o | output | 1 | Block accepts an input word |
| word_i | input | 32 | Input memory word |
| pair_valid_o | output | 1 | Output pair valid |
| pair_ready_i | input | 1 | Consumer takes the pair |
| left_o | output | 16 | Left sample |
| right_o | output | 16 | Right sample |

## Verification
Random words are sent in each of the sixteen combinations of format, byte order and sign option. A wrong lane order, a swap of left and right, or a flip applied in a 16-bit format each yields a distinct mismatch. A phase with long output stalls separates correct holding from data that drifts under back-pressure. A phase that changes the format and option pins every cycle shows whether they are captured with the word or read live. Bursty input valid with random output ready exercises the same-cycle handoff from the last pair of one word to the next word.

// File: rtl/aud_unpack_pkg.sv
package aud_unpack_pkg;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'd0,
    FMT_STEREO8  = 2'd1,
    FMT_MONO16   = 2'd2,
    FMT_STEREO16 = 2'd3
  } aud_fmt_e;

  typedef struct packed {
    aud_fmt_e fmt;
    logic     lsb_first;
    logic     flip_msb;
  } aud_cfg_t;

  // bit 1 of the format code marks full-width samples
  function automatic logic is_narrow(aud_fmt_e f);
    return ~f[1];
  endfunction

  function automatic logic is_mono(aud_fmt_e f);
    return ~f[0];
  endfunction

endpackage

// File: rtl/aud_word_hold.sv
module aud_word_hold
  import aud_unpack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  aud_cfg_t          in_cfg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] held_word,
  output aud_cfg_t          held_cfg,
  output logic [IDX_W-1:0]  pair_idx
);

  localparam int LANES = 1 << IDX_W;

  logic              full_q, full_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q;
  aud_cfg_t          cfg_q;
  logic [IDX_W-1:0]  last_idx;
  logic              give, drain, take;

  always_comb begin
    case (cfg_q.fmt)
      FMT_MONO8:               last_idx = IDX_W'(LANES - 1);
      FMT_STEREO8, FMT_MONO16: last_idx = IDX_W'(LANES / 2 - 1);
      default:                 last_idx = IDX_W'(LANES / 4 - 1);
    endcase
  end

  assign give     = full_q & out_ready;
  assign drain    = give & (idx_q == last_idx);
  assign in_ready = ~full_q | drain;
  assign take     = in_valid & in_ready;

  always_comb begin
    full_d = full_q;
    idx_d  = idx_q;
    if (take) begin
      full_d = 1'b1;
      idx_d  = '0;
    end else if (drain) begin
      full_d = 1'b0;
      idx_d  = '0;
    end else if (give) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cfg_q  <= '{fmt: FMT_MONO8, lsb_first: 1'b0, flip_msb: 1'b0};
    end else if (take) begin
      word_q <= in_word;
      cfg_q  <= in_cfg;
    end
  end

  assign out_valid = full_q;
  assign held_word = word_q;
  assign held_cfg  = cfg_q;
  assign pair_idx  = idx_q;

  // R10: an accepted word is presented on the next cycle
  p_load_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1: the pair index never passes the format's last pair
  p_index_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> idx_q <= last_idx);

  // R1: taking the last pair with no new word empties the holder
  p_last_frees_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (idx_q == last_idx) && !in_valid |=> !out_valid);

endmodule

// File: rtl/aud_lane_pick.sv
module aud_lane_pick
  import aud_unpack_pkg::*;
#(
  parameter int SAMP_W = 16
) (
  input  logic [2*SAMP_W-1:0] word,
  input  aud_fmt_e            fmt,
  input  logic                lsb_first,
  input  logic [1:0]          idx,
  output logic [SAMP_W/2-1:0] byte_l,
  output logic [SAMP_W/2-1:0] byte_r,
  output logic [SAMP_W-1:0]   half_l,
  output logic [SAMP_W-1:0]   half_r
);

  localparam int NARROW_W = SAMP_W / 2;
  localparam int BYTES    = 4;
  localparam int HALVES   = 2;

  logic [NARROW_W-1:0] lane_b [BYTES];
  logic [SAMP_W-1:0]   lane_h [HALVES];

  // lane arrays indexed by address offset inside the word
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign lane_b[k] = lsb_first ? word[k*NARROW_W +: NARROW_W]
                                 : word[(BYTES-1-k)*NARROW_W +: NARROW_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign lane_h[h] = lsb_first ? word[h*SAMP_W +: SAMP_W]
                                 : word[(HALVES-1-h)*SAMP_W +: SAMP_W];
  end

  always_comb begin
    byte_l = lane_b[idx];
    byte_r = lane_b[idx];
    half_l = lane_h[idx[0]];
    half_r = lane_h[idx[0]];
    case (fmt)
      FMT_STEREO8: begin
        byte_l = lane_b[{idx[0], 1'b0}];
        byte_r = lane_b[{idx[0], 1'b1}];
      end
      FMT_STEREO16: begin
        half_l = lane_h[0];
        half_r = lane_h[1];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/aud_widen.sv
module aud_widen #(
  parameter int SAMP_W = 16
) (
  input  logic                narrow,
  input  logic                flip_msb,
  input  logic [SAMP_W/2-1:0] byte_in,
  input  logic [SAMP_W-1:0]   half_in,
  output logic [SAMP_W-1:0]   sample_o
);

  localparam int NARROW_W = SAMP_W / 2;

  logic [NARROW_W-1:0] top_byte;

  always_comb begin
    top_byte = byte_in;
    top_byte[NARROW_W-1] = byte_in[NARROW_W-1] ^ flip_msb;
    if (narrow) sample_o = {top_byte, {NARROW_W{1'b0}}};
    else        sample_o = half_in;
  end

endmodule

// File: rtl/aud_unpacker.sv
module aud_unpacker
  import aud_unpack_pkg::*;
#(
  parameter int SAMP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt_i,
  input  logic                lsb_first_i,
  input  logic                flip_msb_i,
  input  logic                word_valid_i,
  output logic                word_ready_o,
  input  logic [2*SAMP_W-1:0] word_i,
  output logic                pair_valid_o,
  input  logic                pair_ready_i,
  output logic [SAMP_W-1:0]   left_o,
  output logic [SAMP_W-1:0]   right_o
);

  localparam int WORD_W   = 2 * SAMP_W;
  localparam int NARROW_W = SAMP_W / 2;
  localparam int IDX_W    = 2;

  aud_cfg_t            pin_cfg, held_cfg;
  logic [WORD_W-1:0]   held_word;
  logic [IDX_W-1:0]    pair_idx;
  logic [NARROW_W-1:0] ch_byte [2];
  logic [SAMP_W-1:0]   ch_half [2];
  logic [SAMP_W-1:0]   ch_out  [2];

  assign pin_cfg = '{fmt: aud_fmt_e'(fmt_i), lsb_first: lsb_first_i,
                     flip_msb: flip_msb_i};

  aud_word_hold #(.WORD_W(WORD_W), .IDX_W(IDX_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (word_valid_i),
    .in_ready  (word_ready_o),
    .in_word   (word_i),
    .in_cfg    (pin_cfg),
    .out_valid (pair_valid_o),
    .out_ready (pair_ready_i),
    .held_word (held_word),
    .held_cfg  (held_cfg),
    .pair_idx  (pair_idx)
  );

  aud_lane_pick #(.SAMP_W(SAMP_W)) pick_i (
    .word      (held_word),
    .fmt       (held_cfg.fmt),
    .lsb_first (held_cfg.lsb_first),
    .idx       (pair_idx),
    .byte_l    (ch_byte[0]),
    .byte_r    (ch_byte[1]),
    .half_l    (ch_half[0]),
    .half_r    (ch_half[1])
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    aud_widen #(.SAMP_W(SAMP_W)) widen_i (
      .narrow   (is_narrow(held_cfg.fmt)),
      .flip_msb (held_cfg.flip_msb),
      .byte_in  (ch_byte[c]),
      .half_in  (ch_half[c]),
      .sample_o (ch_out[c])
    );
  end

  assign left_o  = ch_out[0];
  assign right_o = ch_out[1];

  // R8: mono formats drive the same sample on both channels
  p_mono_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && is_mono(held_cfg.fmt) |-> left_o == right_o);

  // R5: narrow samples leave the low byte zero
  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && is_narrow(held_cfg.fmt)
    |-> (left_o[NARROW_W-1:0] == '0) && (right_o[NARROW_W-1:0] == '0));

  // R9: a stalled pair is held unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid_o && !pair_ready_i
    |=> pair_valid_o && $stable(left_o) && $stable(right_o));

endmodule

// File: tb/aud_unpacker_tb.sv
module aud_unpacker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_i;
  logic        lsb_first_i, flip_msb_i;
  logic        word_valid_i, word_ready_o;
  logic [31:0] word_i;
  logic        pair_valid_o, pair_ready_i;
  logic [15:0] left_o, right_o;

  int vectors = 0;
  int errors  = 0;

  logic [15:0] exp_l[$];
  logic [15:0] exp_r[$];
  string       exp_tag[$];

  always #4 clk = ~clk;

  aud_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .lsb_first_i(lsb_first_i),
    .flip_msb_i(flip_msb_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .word_i(word_i),
    .pair_valid_o(pair_valid_o), .pair_ready_i(pair_ready_i),
    .left_o(left_o), .right_o(right_o)
  );

  function automatic logic [7:0] mem_byte(logic [31:0] w, bit le, int a);
    return le ? w[8*a +: 8] : w[8*(3-a) +: 8];
  endfunction

  function automatic logic [15:0] mem_half(logic [31:0] w, bit le, int h);
    return le ? w[16*h +: 16] : w[16*(1-h) +: 16];
  endfunction

  function automatic logic [15:0] widen8(logic [7:0] b, bit sc);
    return {b[7] ^ sc, b[6:0], 8'h00};
  endfunction

  function automatic string tag_of(int f, bit le, bit sc);
    if (!le)            return "R4";
    if (f < 2 && sc)    return "R6";
    if (f >= 2 && sc)   return "R7";
    if (f == 0)         return "R5";
    if (f == 1)         return "R2";
    if (f == 2)         return "R8";
    return "R3";
  endfunction

  task automatic push_word(logic [31:0] w, int f, bit le, bit sc, string t);
    case (f)
      0: for (int a = 0; a < 4; a++) begin
           exp_l.push_back(widen8(mem_byte(w, le, a), sc));
           exp_r.push_back(widen8(mem_byte(w, le, a), sc));
           exp_tag.push_back(t);
         end
      1: for (int p = 0; p < 2; p++) begin
           exp_l.push_back(widen8(mem_byte(w, le, 2*p), sc));
           exp_r.push_back(widen8(mem_byte(w, le, 2*p+1), sc));
           exp_tag.push_back(t);
         end
      2: for (int h = 0; h < 2; h++) begin
           exp_l.push_back(mem_half(w, le, h));
           exp_r.push_back(mem_half(w, le, h));
           exp_tag.push_back(t);
         end
      default: begin
           exp_l.push_back(mem_half(w, le, 0));
           exp_r.push_back(mem_half(w, le, 1));
           exp_tag.push_back(t);
         end
    endcase
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // mode 0: fixed config; 1: config changes every cycle; 2: heavy stall
  task automatic run(int n, int mode, int f, bit le, bit sc);
    for (int i = 0; i < n; i++) begin
      bit exp_rdy;
      @(negedge clk);
      if (mode == 1) begin
        fmt_i       = 2'($urandom);
        lsb_first_i = 1'($urandom);
        flip_msb_i  = 1'($urandom);
      end else begin
        fmt_i       = 2'(f);
        lsb_first_i = le;
        flip_msb_i  = sc;
      end
      word_valid_i = ($urandom % 4) != 0;
      word_i       = $urandom;
      pair_ready_i = (mode == 2) ? (($urandom % 6) == 0) : (($urandom % 3) != 0);
      #1;
      check("R1", "pair_valid", 32'(pair_valid_o), 32'(exp_l.size() != 0));
      exp_rdy = (exp_l.size() == 0) || (exp_l.size() == 1 && pair_ready_i);
      check("R10", "word_ready", 32'(word_ready_o), 32'(exp_rdy));
      if (pair_valid_o && exp_l.size() != 0) begin
        string t;
        t = (mode == 2) ? "R9" : exp_tag[0];
        check(t, "left", 32'(left_o), 32'(exp_l[0]));
        check(t, "right", 32'(right_o), 32'(exp_r[0]));
      end
      if (pair_valid_o && pair_ready_i && exp_l.size() != 0) begin
        void'(exp_l.pop_front());
        void'(exp_r.pop_front());
        void'(exp_tag.pop_front());
      end
      if (word_valid_i && word_ready_o)
        push_word(word_i, int'(fmt_i), lsb_first_i, flip_msb_i,
                  (mode == 1) ? "R12" : tag_of(int'(fmt_i), lsb_first_i, flip_msb_i));
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fmt_i = 2'd0; lsb_first_i = 1'b0; flip_msb_i = 1'b0;
    word_valid_i = 1'b0; word_i = '0; pair_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R11", "reset pair_valid", 32'(pair_valid_o), 32'd0);
    check("R11", "reset word_ready", 32'(word_ready_o), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 4; f++)
      for (int le = 0; le < 2; le++)
        for (int sc = 0; sc < 2; sc++)
          run(80, 0, f, 1'(le), 1'(sc));
    run(400, 1, 0, 1'b0, 1'b0);
    run(200, 2, 1, 1'b1, 1'b1);
    run(200, 2, 2, 1'b0, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule